// File: doc/BRIEF.md
# I2C Target Register Port

This block is a target on a two-wire serial control bus. A host uses it to write and read back a small file of 8-bit control registers. SCL and SDA are sampled on a fast system clock, first through a two-flop synchronizer and then through a short glitch filter. The block drives SDA only through a pull-low enable, and an external pull-up returns the line high.

The 7-bit device address is a fixed base of 0x08 ORed with two strap inputs, so up to four targets can share one bus. A write carries the register number and then one data byte. A read first writes the register number, then sends a repeated START and an address byte with the read bit set, and the target returns the selected register MSB first. After reset the block ignores the bus until a lock input has been held high for a set number of clock cycles. Three register bits drive power-down outputs for the clock, DAC and ADC sections.

Top module: `i2c_reg_target`

## Requirements
- R1: `sdaPullLow` is a pull-low enable, never a data level. It is low during reset and whenever the target is not sending an ACK or a 0 data bit. In particular it is low after a STOP.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP, and a STOP in any state sends the target back to idle. A transfer cut short by a STOP before its data byte writes nothing.
- R3: The device address is 0x08 ORed with {addrStrap[1], addrStrap[0]}. It sits in bits 7:1 of the first byte after a START, and bit 0 is R/W (0 means write). On a match the target ACKs. On a mismatch it NACKs and also NACKs every later byte until the next START or STOP.
- R4: A write runs as address byte with R/W=0, ACK, register-number byte, ACK, data byte, ACK, STOP. It stores the data byte in the selected register.
- R5: A read sets the register number with a write-form address byte and a register-number byte. It then sends a repeated START and an address byte with R/W=1. After the ACK the target shifts the selected register out MSB first.
- R6: Reset returns every register to its default value, ((i × 0x1D) mod 256) AND 0xFE for register i.
- R7: After reset is released, the target does not acknowledge any byte until `lockIn` has been high for INIT_CYCLES (256) consecutive clock cycles. Dropping `lockIn` before that point restarts the count.
- R8: `pdClk`, `pdDac` and `pdAdc` equal bit 0 of registers 0x00, 0x04 and 0x0E. Setting one of these bits changes no other register.
- R9: The register file holds registers 0x00 to 0x10. A write to a higher register number is acknowledged but discarded, and a read from one returns 0x00.
- R10: The target starts pulling SDA low only while SCL is low, after it has seen a falling edge of SCL.
- R11: A write stores one data byte. A further byte in the same transfer is NACKed and leaves the register file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| lockIn | input | 1 | Clock-lock indication that starts the initialization count |
| addrStrap | input | 2 | Strap bits ORed into the low two device-address bits |
| sclIn | input | 1 | Bus clock as seen at the pad |
| sdaIn | input | 1 | Bus data as seen at the pad |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| pdClk | output | 1 | Clock-section power-down |
| pdDac | output | 1 | DAC-section power-down |
| pdAdc | output | 1 | ADC-section power-down |

## Verification
The bench builds the block with its defaults: 17 registers, a 256-cycle initialization, a three-sample filter and a base address of 0x08. It drives the bus with a 12-cycle quarter bit, which leaves the filter latency well inside the low phase of SCL. A register count of 17 leaves numbers 0x11 and above unused, so the out-of-range path is reachable with an ordinary register-number byte. The short initialization lets the bench reset twice and then sweep every register back to its default. The straps are switched between 00 and 11 so that both the base address and an ORed address are checked, and random writes and read-backs go to random registers, including the power-down ones.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_REG, ST_REG_ACK,
    ST_DATA, ST_DATA_ACK, ST_READ, ST_IGNORE
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // sample SDA into receive shifter
    logic setPtr;    // received byte becomes register pointer
    logic writeReg;  // received byte is stored at pointer
    logic loadTx;    // load transmit shifter from pointer
    logic shiftTx;   // advance transmit shifter by one bit
  } dpStrobe_t;

  // power-on value of register idx
  function automatic logic [7:0] regDefault(input int unsigned idx);
    logic [7:0] v;
    v = 8'(idx * 29);
    return v & 8'hFE;
  endfunction

endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    histQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      histQ    <= '1;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_STAGES-1]};
      // output follows only a level held for FILT_LEN samples
      if (&histQ)       cleanOut <= 1'b1;
      else if (~|histQ) cleanOut <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS    = 17,
  parameter int PD_CLK_ADDR = 0,
  parameter int PD_DAC_ADDR = 4,
  parameter int PD_ADC_ADDR = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic       txBit,
  output logic       pdClk,
  output logic       pdDac,
  output logic       pdAdc
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [7:0]       regFile [NUM_REGS];
  logic [7:0]       ptrQ;
  logic [7:0]       txQ;
  logic [7:0]       rdData;
  logic             ptrInRange;
  logic [IDX_W-1:0] ptrIdx;

  assign ptrInRange = (ptrQ < 8'(NUM_REGS));
  assign ptrIdx     = ptrQ[IDX_W-1:0];

  always_comb begin
    rdData = 8'h00;
    if (ptrInRange) rdData = regFile[ptrIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      ptrQ   <= '0;
      txQ    <= '0;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
      if (strobe.setPtr)  ptrQ   <= rxByte;
      if (strobe.loadTx)       txQ <= rdData;
      else if (strobe.shiftTx) txQ <= {txQ[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= regDefault(unsigned'(i));
    end else if (strobe.writeReg && ptrInRange) begin
      regFile[ptrIdx] <= rxByte;
    end
  end

  assign txBit = txQ[7];
  assign pdClk = regFile[PD_CLK_ADDR][0];
  assign pdDac = regFile[PD_DAC_ADDR][0];
  assign pdAdc = regFile[PD_ADC_ADDR][0];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int INIT_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lockIn,
  input  logic [6:0] devAddr,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  strobe,
  output logic       sdaPullLow,
  output logic       initDone
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  tgtState_e  state;
  logic [3:0] bitCnt;
  logic       rwQ, ackDrive, txDrive;
  logic       sclPrev, sdaPrev;
  logic [CNT_W-1:0] initCnt;
  logic       sclRise, sclFall, startCond, stopCond, rxState;

  assign sclRise   = sclF & ~sclPrev;
  assign sclFall   = ~sclF & sclPrev;
  assign startCond = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopCond  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign rxState   = (state == ST_ADDR) || (state == ST_REG) || (state == ST_DATA);
  assign sdaPullLow = ackDrive | (txDrive & ~txBit);

  // initialization gate: lock must be held INIT_CYCLES cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt  <= '0;
      initDone <= 1'b0;
    end else if (!initDone) begin
      if (!lockIn)                                   initCnt  <= '0;
      else if (initCnt == CNT_W'(INIT_CYCLES - 1))   initDone <= 1'b1;
      else                                           initCnt  <= initCnt + 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    if (initDone && !startCond && !stopCond) begin
      if (sclRise && rxState && bitCnt < 4'd8) strobe.shiftIn = 1'b1;
      if (sclFall) begin
        case (state)
          ST_ADDR_ACK: strobe.loadTx   = rwQ;
          ST_REG:      strobe.setPtr   = (bitCnt == 4'd8);
          ST_DATA:     strobe.writeReg = (bitCnt == 4'd8);
          ST_READ:     strobe.shiftTx  = (bitCnt < 4'd8);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      rwQ      <= 1'b0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      if (!initDone || stopCond) begin
        state    <= ST_IDLE;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
      end else if (startCond) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
      end else begin
        if (sclRise && bitCnt < 4'd8 && (rxState || state == ST_READ))
          bitCnt <= bitCnt + 4'd1;
        if (sclFall) begin
          case (state)
            ST_ADDR: if (bitCnt == 4'd8) begin
              if (rxByte[7:1] == devAddr) begin
                ackDrive <= 1'b1;
                rwQ      <= rxByte[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_ADDR_ACK: begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              txDrive  <= rwQ;
              state    <= rwQ ? ST_READ : ST_REG;
            end
            ST_REG: if (bitCnt == 4'd8) begin
              ackDrive <= 1'b1;
              state    <= ST_REG_ACK;
            end
            ST_REG_ACK: begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              state    <= ST_DATA;
            end
            ST_DATA: if (bitCnt == 4'd8) begin
              ackDrive <= 1'b1;
              state    <= ST_DATA_ACK;
            end
            ST_DATA_ACK: begin
              ackDrive <= 1'b0;
              state    <= ST_IGNORE;
            end
            ST_READ: if (bitCnt == 4'd8) begin
              txDrive <= 1'b0;
              state   <= ST_IGNORE;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int         NUM_REGS    = 17,
  parameter int         INIT_CYCLES = 256,
  parameter int         FILT_LEN    = 3,
  parameter logic [6:0] BASE_ADDR   = 7'h08,
  parameter int         PD_CLK_ADDR = 0,
  parameter int         PD_DAC_ADDR = 4,
  parameter int         PD_ADC_ADDR = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lockIn,
  input  logic [1:0] addrStrap,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic       pdClk,
  output logic       pdDac,
  output logic       pdAdc
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines, cleanLines;
  logic       sclClean, sdaClean, txBit, initDone;
  logic [7:0] rxByte;
  logic [6:0] devAddr;
  dpStrobe_t  strobe;

  assign rawLines = {sdaIn, sclIn};
  assign sclClean = cleanLines[0];
  assign sdaClean = cleanLines[1];
  assign devAddr  = BASE_ADDR | {5'b0, addrStrap};

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    i2c_tgt_filter #(.SYNC_STAGES(2), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[gi]), .cleanOut(cleanLines[gi])
    );
  end

  i2c_tgt_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .devAddr(devAddr),
    .sclF(sclClean), .sdaF(sdaClean), .rxByte(rxByte), .txBit(txBit),
    .strobe(strobe), .sdaPullLow(sdaPullLow), .initDone(initDone)
  );

  i2c_tgt_datapath #(
    .NUM_REGS(NUM_REGS), .PD_CLK_ADDR(PD_CLK_ADDR),
    .PD_DAC_ADDR(PD_DAC_ADDR), .PD_ADC_ADDR(PD_ADC_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaClean),
    .rxByte(rxByte), .txBit(txBit),
    .pdClk(pdClk), .pdDac(pdDac), .pdAdc(pdAdc)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk,
  input logic rstN,
  input logic lockIn,
  input logic sclF,
  input logic sdaPullLow,
  input logic initDone,
  input logic pdClk,
  input logic pdDac,
  input logic pdAdc
);
  assert_no_drive_while_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !sdaPullLow);

  assert_init_needs_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> $past(lockIn));

  assert_init_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_defaults_before_init_R6: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !(pdClk | pdDac | pdAdc));

  assert_pull_starts_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclF);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk(clk), .rstN(rstN), .lockIn(lockIn), .sclF(sclClean),
  .sdaPullLow(sdaPullLow), .initDone(initDone),
  .pdClk(pdClk), .pdDac(pdDac), .pdAdc(pdAdc)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
  localparam int Q      = 12;   // quarter bit in clocks
  localparam int NREG   = 17;
  localparam int INITC  = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0, lockIn = 1'b0;
  logic [1:0] addrStrap = 2'b00;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine, sdaPullLow, pdClk, pdDac, pdAdc;
  int   nChecks = 0, nFails = 0, badStarts = 0;
  logic prevPull = 1'b0;
  logic [7:0] model [NREG];
  bit   finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  assign sdaLine = sdaM & ~sdaPullLow;

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .addrStrap(addrStrap),
    .sclIn(sclM), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .pdClk(pdClk), .pdDac(pdDac), .pdAdc(pdAdc)
  );

  // R10 monitor: a pull-down must never begin while SCL is high
  always @(negedge clk) begin
    if (rstN && sdaPullLow && !prevPull && sclM) badStarts++;
    prevPull = sdaPullLow;
  end

  function automatic logic [7:0] defVal(input int i);
    logic [7:0] v;
    v = 8'(i * 29);
    return v & 8'hFE;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    acked = !sdaLine;
    waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic recvByte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
      b[i] = sdaLine;
      waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ(); // NACK
  endtask

  task automatic writeReg(input logic [6:0] dev, input logic [7:0] ra,
                          input logic [7:0] d, output bit allAck);
    bit a0, a1, a2;
    busStart();
    sendByte({dev, 1'b0}, a0);
    sendByte(ra, a1);
    sendByte(d, a2);
    busStop();
    allAck = a0 & a1 & a2;
  endtask

  task automatic readReg(input logic [6:0] dev, input logic [7:0] ra,
                         output logic [7:0] d, output bit allAck);
    bit a0, a1, a2;
    busStart();
    sendByte({dev, 1'b0}, a0);
    sendByte(ra, a1);
    busStart();
    sendByte({dev, 1'b1}, a2);
    recvByte(d);
    busStop();
    allAck = a0 & a1 & a2;
  endtask

  task automatic doReset();
    rstN = 1'b0; lockIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    lockIn = 1'b1;
    repeat (INITC + 20) @(negedge clk);
    for (int i = 0; i < NREG; i++) model[i] = defVal(i);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit ack, ok;
    logic [7:0] rd;
    logic [6:0] dev;
    int unsigned seedInit;
    seedInit = $urandom(32'd20240611);
    for (int i = 0; i < NREG; i++) model[i] = defVal(i);

    // reset state: R1, R8
    repeat (4) @(negedge clk);
    check(sdaPullLow == 1'b0, "R1", "pull-low in reset", sdaPullLow, 0);
    check({pdClk, pdDac, pdAdc} == 3'b000, "R8", "power-downs in reset",
          {pdClk, pdDac, pdAdc}, 0);

    // R7: busy before lock -> NACK
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    busStart(); sendByte({7'h08, 1'b0}, ack); busStop();
    check(ack == 1'b0, "R7", "address ACK before lock", ack, 0);
    // R7: lock dropped early restarts count
    lockIn = 1'b1; repeat (INITC - 40) @(negedge clk);
    lockIn = 1'b0; repeat (3) @(negedge clk);
    lockIn = 1'b1; repeat (INITC - 40) @(negedge clk);
    lockIn = 1'b0;
    busStart(); sendByte({7'h08, 1'b0}, ack); busStop();
    check(ack == 1'b0, "R7", "ACK after interrupted lock", ack, 0);
    lockIn = 1'b1; repeat (INITC + 20) @(negedge clk);

    // R4, R5: write then read back register 0x06
    dev = 7'h08;
    writeReg(dev, 8'h06, 8'h5A, ok);
    check(ok, "R4", "write 0x06 acks", ok, 1);
    model[6] = 8'h5A;
    readReg(dev, 8'h06, rd, ok);
    check(ok && rd == 8'h5A, "R5", "read back 0x06", rd, 8'h5A);

    // R3: wrong address NACK and later bytes ignored
    busStart(); sendByte({7'h09, 1'b0}, ack);
    check(ack == 1'b0, "R3", "wrong address NACK", ack, 0);
    sendByte(8'h06, ack);
    check(ack == 1'b0, "R3", "byte after mismatch NACK", ack, 0);
    busStop();
    check(sdaPullLow == 1'b0, "R1", "released after STOP", sdaPullLow, 0);

    // R3: strap 11 -> address 0x0B
    addrStrap = 2'b11; dev = 7'h0B;
    repeat (4) @(negedge clk);
    busStart(); sendByte({7'h08, 1'b0}, ack); busStop();
    check(ack == 1'b0, "R3", "base address NACK with strap 11", ack, 0);
    writeReg(dev, 8'h03, 8'hC3, ok); model[3] = 8'hC3;
    readReg(dev, 8'h03, rd, ok);
    check(ok && rd == 8'hC3, "R3", "strapped address read", rd, 8'hC3);

    // R4, R5: random writes and read-backs
    for (int n = 0; n < 14; n++) begin
      int ra;
      logic [7:0] d;
      ra = int'($urandom_range(0, NREG - 1));
      d  = 8'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        writeReg(dev, 8'(ra), d, ok); model[ra] = d;
        check(ok, "R4", "random write acks", ok, 1);
      end else begin
        readReg(dev, 8'(ra), rd, ok);
        check(ok && rd == model[ra], "R5", "random read", rd, model[ra]);
      end
    end

    // R8: power-down bit in register 0x04
    writeReg(dev, 8'h04, 8'h01, ok); model[4] = 8'h01;
    repeat (4) @(negedge clk);
    check({pdClk, pdDac, pdAdc} == {model[0][0], 1'b1, model[14][0]}, "R8",
          "DAC power-down set", {pdClk, pdDac, pdAdc}, {model[0][0], 1'b1, model[14][0]});
    readReg(dev, 8'h06, rd, ok);
    check(rd == model[6], "R8", "other register retained", rd, model[6]);

    // R9: out-of-range write discarded, read gives 0
    writeReg(dev, 8'h12, 8'h77, ok);
    check(ok, "R9", "out-of-range write acked", ok, 1);
    readReg(dev, 8'h12, rd, ok);
    check(rd == 8'h00, "R9", "out-of-range read", rd, 0);
    readReg(dev, 8'h10, rd, ok);
    check(rd == model[16], "R9", "top register untouched", rd, model[16]);

    // R11: second data byte NACKed
    busStart(); sendByte({dev, 1'b0}, ack); sendByte(8'h05, ack);
    sendByte(8'h11, ack); sendByte(8'h22, ack); busStop();
    model[5] = 8'h11;
    check(ack == 1'b0, "R11", "second data byte NACK", ack, 0);
    readReg(dev, 8'h05, rd, ok);
    check(rd == 8'h11, "R11", "register keeps first byte", rd, 8'h11);

    // R2: STOP before data writes nothing
    busStart(); sendByte({dev, 1'b0}, ack); sendByte(8'h07, ack); busStop();
    check(sdaPullLow == 1'b0, "R2", "idle after early STOP", sdaPullLow, 0);
    writeReg(dev, 8'h08, 8'h3C, ok); model[8] = 8'h3C;
    readReg(dev, 8'h07, rd, ok);
    check(ok && rd == model[7], "R2", "no write on early STOP", rd, model[7]);

    // R6: reset restores every default
    doReset();
    check({pdClk, pdDac, pdAdc} == 3'b000, "R6", "power-downs after reset",
          {pdClk, pdDac, pdAdc}, 0);
    for (int i = 0; i < NREG; i++) begin
      readReg(dev, 8'(i), rd, ok);
      check(ok && rd == defVal(i), "R6", $sformatf("default of reg %0d", i), rd, defVal(i));
    end

    check(badStarts == 0, "R10", "pull-downs begun with SCL high", badStarts, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule